// File: doc/BRIEF.md
# Heartbeat and Event Alert Sequencer

This block decides when a management controller puts an alert message on a shared two-wire management bus and what that message carries. It keeps a heartbeat timer that runs while the platform sleeps, is locked up, or has seen a second watchdog expiry. It captures edges on a set of event lines and turns them into immediate event messages. It also accepts a software "send now" request. Every message carries a type and a rolling 4-bit sequence number, and a message that completes without a collision advances that number.

The block does not shift bits onto the bus. It raises a request towards a simple transmitter, holds the message fields steady while the request is high, and waits for a done or a collision pulse. It starts a message only when the transmitter reports the bus idle. After a collision it drops the request, waits for idle again and sends the same message once more.

After a second watchdog expiry, one reset request may pull the system reset line. The line stays asserted until the platform acknowledges it. No further attempt is made until the block itself is reset.

Top module: `hb_alert_seq`

## Requirements
- R1: After reset, txReq, sysRst and secondToSts are low. The first message sent carries sequence number 0.
- R2: While pwrState is sleeping (2'b01), a heartbeat (txType 0) goes out periodically. txReq rises exactly TICK_DIV*HB_TICKS+2 clock edges after the edge that accepted the previous message's txDone.
- R3: With pwrState working (2'b00), no heartbeat is sent unless lockedUp or secondToSts is high. With pwrState off (2'b10 or 2'b11), no heartbeat is sent.
- R4: A rising or falling edge on evtIn[i] while sleeping produces an event message (txType 1) with txEvtFlags bit i set. When a heartbeat is pending at the same time, the event is sent first. Heartbeat and send-now messages carry txEvtFlags of zero.
- R5: txSeq is a 4-bit count. It advances by one, modulo 16, only when a message completes with txDone. It stays unchanged after a collision.
- R6: txReq rises only after a cycle with busIdle high. A txColl drops txReq, and the same type, sequence and flags are sent again once busIdle is seen.
- R7: Once a message has been chosen, it completes even if pwrState changes to working before it goes out.
- R8: A sendNowReq pulse produces a send-now message (txType 2) in any power state. Event edges in the working state are dropped, except during a send-now message. An edge caught during a send-now message is held and produces a single event message once the state becomes sleeping.
- R9: A wdTimeout pulse sets secondToSts, and a stsClr pulse clears it. While it is set, heartbeats are sent in the working state.
- R10: An rstReq while secondToSts is set starts one reset attempt. sysRst stays high until rstDone, and no message starts during that time. Later rstReq pulses are ignored until the block is reset.
- R11: While txReq is high, txType, txSeq and txEvtFlags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrState | input | 2 | 00 working, 01 sleeping, 1x off |
| lockedUp | input | 1 | Working state is hung; enables heartbeats |
| evtIn | input | EVT_W | Asynchronous event lines (thermal, intrusion, general purpose) |
| sendNowReq | input | 1 | Software pulse requesting an immediate alert |
| wdTimeout | input | 1 | Pulse: second watchdog expiry |
| stsClr | input | 1 | Pulse: software clear of the second-expiry status |
| rstReq | input | 1 | Pulse: reset attempt request |
| rstDone | input | 1 | Pulse: platform finished the reset attempt |
| busIdle | input | 1 | Transmitter reports the bus idle |
| txDone | input | 1 | Pulse: message sent without collision |
| txColl | input | 1 | Pulse: collision, message lost |
| txReq | output | 1 | Request to send the presented message |
| txType | output | 2 | 0 heartbeat, 1 event, 2 send-now |
| txSeq | output | SEQ_W | Sequence number of the presented message |
| txEvtFlags | output | EVT_W | Event lines reported by an event message |
| sysRst | output | 1 | System reset drive during the single attempt |
| secondToSts | output | 1 | Second watchdog expiry status |

## Verification
Message content is checked when txReq is seen high at a falling edge. It becomes high two edges after the controller leaves idle, which is at least five edges after an event line toggles, because of the two-stage synchroniser and the edge register. A scoreboard therefore checks order and content, not the exact edge. The one exact latency, the heartbeat period of TICK_DIV*HB_TICKS+2 edges after the accepting txDone, is measured by counting cycles from the falling edge where the bench drives txDone. Status and reset outputs are registered one edge after their input pulse and are sampled at the next falling edge. Quiet-period checks wait shorter than one heartbeat interval so that a real heartbeat cannot hide a wrongly sent message.

// File: rtl/hb_alert_pkg.sv
package hb_alert_pkg;

  localparam logic [1:0] PWR_WORK  = 2'b00;
  localparam logic [1:0] PWR_SLEEP = 2'b01;

  typedef enum logic [1:0] {
    MSG_HB  = 2'd0,
    MSG_EVT = 2'd1,
    MSG_NOW = 2'd2
  } msgType_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_IDLE,
    ST_SEND,
    ST_BACKOFF,
    ST_HOLD_RESET
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     pickEvt;
    logic     pickNow;
    logic     msgOk;
    logic     rstStart;
    logic     nowBusy;
    msgType_e curType;
  } ctrlStb_t;

  // request status from datapath to control
  typedef struct packed {
    logic rstPend;
    logic evtGo;
    logic nowPend;
    logic hbDue;
  } dpStat_t;

endpackage

// File: rtl/hb_alert_edge.sv
module hb_alert_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic edgeOut
);

  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[STAGES-2:0], rawIn};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= rawIn;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[STAGES-1];
  end

  assign edgeOut = syncQ[STAGES-1] ^ lastQ;

endmodule

// File: rtl/hb_alert_dp.sv
module hb_alert_dp
  import hb_alert_pkg::*;
#(
  parameter int TICK_DIV    = 100_000_000,
  parameter int HB_TICKS    = 31,
  parameter int EVT_W       = 3,
  parameter int SEQ_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       pwrState,
  input  logic             lockedUp,
  input  logic [EVT_W-1:0] evtIn,
  input  logic             sendNowReq,
  input  logic             wdTimeout,
  input  logic             stsClr,
  input  logic             rstReq,
  input  ctrlStb_t         stb,
  output dpStat_t          stat,
  output logic [SEQ_W-1:0] seqNum,
  output logic [EVT_W-1:0] evtFlagsOut,
  output logic             secondToSts
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int HB_W  = $clog2(HB_TICKS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [HB_W-1:0]  HB_LOAD  = HB_W'(HB_TICKS);
  localparam logic [HB_W-1:0]  HB_ONE   = HB_W'(1);

  logic             isWork, isSleep, hbEn, capEn, tick;
  logic [EVT_W-1:0] evtEdge, evtPend, evtFlags, evtDoneMask;
  logic             nowPend, stsQ, rstTried, rstPend, hbDue;
  logic [PRE_W-1:0] preCnt;
  logic [HB_W-1:0]  hbLeft;
  logic [SEQ_W-1:0] seqQ;

  assign isWork  = (pwrState == PWR_WORK);
  assign isSleep = (pwrState == PWR_SLEEP);
  assign hbEn    = isSleep | (isWork & (lockedUp | stsQ));

  // one synchroniser and edge detector per event line
  generate
    for (genvar i = 0; i < EVT_W; i++) begin : g_evt
      hb_alert_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rstN   (rstN),
        .rawIn  (evtIn[i]),
        .edgeOut(evtEdge[i])
      );
    end
  endgenerate

  // event capture: always while sleeping, in working only during send-now
  assign capEn       = isSleep | (isWork & stb.nowBusy);
  assign evtDoneMask = (stb.msgOk && stb.curType == MSG_EVT) ? evtFlags : '0;

  always_ff @(posedge clk) begin
    if (!rstN)                 evtPend <= '0;
    else if (!isWork && !isSleep) evtPend <= '0;
    else                       evtPend <= (evtPend & ~evtDoneMask) | (capEn ? evtEdge : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            evtFlags <= '0;
    else if (stb.pickEvt) evtFlags <= evtPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            nowPend <= 1'b0;
    else if (sendNowReq)  nowPend <= 1'b1;
    else if (stb.pickNow) nowPend <= 1'b0;
  end

  // second-expiry status, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)          stsQ <= 1'b0;
    else if (wdTimeout) stsQ <= 1'b1;
    else if (stsClr)    stsQ <= 1'b0;
  end

  // single reset attempt bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstTried <= 1'b0;
      rstPend  <= 1'b0;
    end else if (stb.rstStart) begin
      rstTried <= 1'b1;
      rstPend  <= 1'b0;
    end else if (!stsQ) begin
      rstPend  <= 1'b0;
    end else if (rstReq && !rstTried) begin
      rstPend  <= 1'b1;
    end
  end

  // prescaled heartbeat timer, reloaded on every good message
  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      hbLeft <= HB_LOAD;
      hbDue  <= 1'b0;
    end else if (stb.msgOk || !hbEn) begin
      preCnt <= '0;
      hbLeft <= HB_LOAD;
      hbDue  <= 1'b0;
    end else begin
      if (tick) preCnt <= '0;
      else      preCnt <= preCnt + 1'b1;
      if (tick && hbLeft != '0) begin
        hbLeft <= hbLeft - 1'b1;
        if (hbLeft == HB_ONE) hbDue <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          seqQ <= '0;
    else if (stb.msgOk) seqQ <= seqQ + 1'b1;
  end

  assign stat.rstPend = rstPend;
  assign stat.evtGo   = isSleep & (|evtPend);
  assign stat.nowPend = nowPend;
  assign stat.hbDue   = hbDue;

  assign seqNum      = seqQ;
  assign evtFlagsOut = (stb.curType == MSG_EVT) ? evtFlags : '0;
  assign secondToSts = stsQ;

endmodule

// File: rtl/hb_alert_ctrl.sv
module hb_alert_ctrl
  import hb_alert_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStat_t  stat,
  input  logic     busIdle,
  input  logic     txDone,
  input  logic     txColl,
  input  logic     rstDone,
  output ctrlStb_t stb,
  output logic     txReq,
  output logic     sysRst
);

  seqState_e state, stateNx;
  msgType_e  curType, curTypeNx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curType <= MSG_HB;
    end else begin
      state   <= stateNx;
      curType <= curTypeNx;
    end
  end

  always_comb begin
    stateNx     = state;
    curTypeNx   = curType;
    stb         = '0;
    stb.curType = curType;
    case (state)
      ST_IDLE: begin
        if (stat.rstPend) begin
          stateNx      = ST_HOLD_RESET;
          stb.rstStart = 1'b1;
        end else if (stat.evtGo) begin
          stateNx     = ST_WAIT_IDLE;
          curTypeNx   = MSG_EVT;
          stb.pickEvt = 1'b1;
        end else if (stat.nowPend) begin
          stateNx     = ST_WAIT_IDLE;
          curTypeNx   = MSG_NOW;
          stb.pickNow = 1'b1;
        end else if (stat.hbDue) begin
          stateNx   = ST_WAIT_IDLE;
          curTypeNx = MSG_HB;
        end
      end
      ST_WAIT_IDLE:  if (busIdle) stateNx = ST_SEND;
      ST_SEND: begin
        if (txDone) begin
          stateNx   = ST_IDLE;
          stb.msgOk = 1'b1;
        end else if (txColl) begin
          stateNx = ST_BACKOFF;
        end
      end
      ST_BACKOFF:    if (busIdle) stateNx = ST_SEND;
      ST_HOLD_RESET: if (rstDone) stateNx = ST_IDLE;
      default:       stateNx = ST_IDLE;
    endcase
    stb.nowBusy = (curType == MSG_NOW) &&
                  (state == ST_WAIT_IDLE || state == ST_SEND || state == ST_BACKOFF);
  end

  assign txReq  = (state == ST_SEND);
  assign sysRst = (state == ST_HOLD_RESET);

endmodule

// File: rtl/hb_alert_seq.sv
module hb_alert_seq
  import hb_alert_pkg::*;
#(
  parameter int TICK_DIV    = 100_000_000,
  parameter int HB_TICKS    = 31,
  parameter int EVT_W       = 3,
  parameter int SEQ_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       pwrState,
  input  logic             lockedUp,
  input  logic [EVT_W-1:0] evtIn,
  input  logic             sendNowReq,
  input  logic             wdTimeout,
  input  logic             stsClr,
  input  logic             rstReq,
  input  logic             rstDone,
  input  logic             busIdle,
  input  logic             txDone,
  input  logic             txColl,
  output logic             txReq,
  output logic [1:0]       txType,
  output logic [SEQ_W-1:0] txSeq,
  output logic [EVT_W-1:0] txEvtFlags,
  output logic             sysRst,
  output logic             secondToSts
);

  ctrlStb_t stb;
  dpStat_t  stat;

  hb_alert_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .busIdle(busIdle),
    .txDone (txDone),
    .txColl (txColl),
    .rstDone(rstDone),
    .stb    (stb),
    .txReq  (txReq),
    .sysRst (sysRst)
  );

  hb_alert_dp #(
    .TICK_DIV   (TICK_DIV),
    .HB_TICKS   (HB_TICKS),
    .EVT_W      (EVT_W),
    .SEQ_W      (SEQ_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pwrState   (pwrState),
    .lockedUp   (lockedUp),
    .evtIn      (evtIn),
    .sendNowReq (sendNowReq),
    .wdTimeout  (wdTimeout),
    .stsClr     (stsClr),
    .rstReq     (rstReq),
    .stb        (stb),
    .stat       (stat),
    .seqNum     (txSeq),
    .evtFlagsOut(txEvtFlags),
    .secondToSts(secondToSts)
  );

  assign txType = stb.curType;

endmodule

// File: rtl/hb_alert_chk.sv
module hb_alert_chk #(
  parameter int EVT_W = 3,
  parameter int SEQ_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busIdle,
  input logic             txDone,
  input logic             txColl,
  input logic             rstDone,
  input logic             txReq,
  input logic [1:0]       txType,
  input logic [SEQ_W-1:0] txSeq,
  input logic [EVT_W-1:0] txEvtFlags,
  input logic             sysRst
);

  logic       sysRstQ;
  logic [1:0] rstRises;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysRstQ  <= 1'b0;
      rstRises <= '0;
    end else begin
      sysRstQ <= sysRst;
      if (sysRst && !sysRstQ && rstRises != 2'd3) rstRises <= rstRises + 1'b1;
    end
  end

  // R6
  req_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> $past(busIdle));

  // R6
  coll_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && txColl && !txDone) |=> !txReq);

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && txDone) |=> (txSeq == SEQ_W'($past(txSeq) + 1'b1)));

  // R5
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> $stable(txSeq));

  // R11
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> ($stable(txType) && $stable(txEvtFlags)));

  // R10
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysRst && !rstDone) |=> sysRst);

  // R10
  rst_no_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sysRst && txReq));

  // R10
  rst_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstRises <= 2'd1);

endmodule

bind hb_alert_seq hb_alert_chk #(.EVT_W(EVT_W), .SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busIdle   (busIdle),
  .txDone    (txDone),
  .txColl    (txColl),
  .rstDone   (rstDone),
  .txReq     (txReq),
  .txType    (txType),
  .txSeq     (txSeq),
  .txEvtFlags(txEvtFlags),
  .sysRst    (sysRst)
);

// File: tb/hb_alert_seq_bench.sv
module hb_alert_seq_bench;

  localparam int DIV = 4;
  localparam int HBT = 8;
  localparam int EW  = 3;
  localparam int SW  = 4;
  localparam int GAP = DIV * HBT + 3;
  localparam int T_HB = 0, T_EVT = 1, T_NOW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    pwrState = 2'b10;
  logic          lockedUp = 1'b0;
  logic [EW-1:0] evtIn = '0;
  logic          sendNowReq = 1'b0, wdTimeout = 1'b0, stsClr = 1'b0;
  logic          rstReq = 1'b0, rstDone = 1'b0;
  logic          busIdle = 1'b1, txDone = 1'b0, txColl = 1'b0;
  logic          txReq, sysRst, secondToSts;
  logic [1:0]    txType;
  logic [SW-1:0] txSeq;
  logic [EW-1:0] txEvtFlags;

  hb_alert_seq #(.TICK_DIV(DIV), .HB_TICKS(HBT), .EVT_W(EW), .SEQ_W(SW)) u_hb_alert_seq (
    .clk(clk), .rstN(rstN), .pwrState(pwrState), .lockedUp(lockedUp), .evtIn(evtIn),
    .sendNowReq(sendNowReq), .wdTimeout(wdTimeout), .stsClr(stsClr), .rstReq(rstReq),
    .rstDone(rstDone), .busIdle(busIdle), .txDone(txDone), .txColl(txColl),
    .txReq(txReq), .txType(txType), .txSeq(txSeq), .txEvtFlags(txEvtFlags),
    .sysRst(sysRst), .secondToSts(secondToSts)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int tests = 0, fails = 0;
  int msgCount = 0, doneCount = 0, doneCyc = 0;
  int respDelay = 2;
  bit gapArm = 0, collNext = 0;
  int expSeq = 0;

  typedef struct { int typ; int seq; int flags; } exp_t;
  exp_t expQ[$];

  task automatic check(bit ok, string tag, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectMsg(int typ, int flags, bit coll);
    exp_t e;
    e.typ = typ; e.seq = expSeq; e.flags = flags;
    expQ.push_back(e);
    if (coll) expQ.push_back(e);
    expSeq = (expSeq + 1) % 16;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  // transmitter model and monitor
  always begin : monitor
    exp_t e;
    @(negedge clk);
    if (rstN && txReq) begin
      msgCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected message, type", int'(txType), -1);
      end else begin
        e = expQ.pop_front();
        check(int'(txType) == e.typ, "R4 message type", int'(txType), e.typ);
        check(int'(txSeq) == e.seq, "R5 sequence number", int'(txSeq), e.seq);
        check(int'(txEvtFlags) == e.flags, "R4 event flags", int'(txEvtFlags), e.flags);
      end
      if (gapArm && txType == 2'(T_HB))
        check(cyc - doneCyc == GAP, "R2 heartbeat interval", cyc - doneCyc, GAP);
      repeat (respDelay) @(negedge clk);
      if (collNext) begin
        collNext = 0;
        txColl = 1'b1;
        @(negedge clk);
        txColl = 1'b0;
      end else begin
        txDone = 1'b1;
        doneCyc = cyc;
        @(negedge clk);
        txDone = 1'b0;
        doneCount++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stimulus
    int base, mc;
    repeat (5) @(negedge clk);
    check(txReq == 1'b0, "R1 txReq in reset", int'(txReq), 0);
    check(sysRst == 1'b0, "R1 sysRst in reset", int'(sysRst), 0);
    check(secondToSts == 1'b0, "R1 status in reset", int'(secondToSts), 0);
    rstN = 1'b1;

    // R3: silent in working without lockup, and in off
    pwrState = 2'b00;
    repeat (60) @(negedge clk);
    check(msgCount == 0, "R3 working quiet", msgCount, 0);
    pwrState = 2'b10;
    repeat (60) @(negedge clk);
    check(msgCount == 0, "R3 off quiet", msgCount, 0);

    // R1 first sequence 0, R2 period while sleeping
    expectMsg(T_HB, 0, 0);
    expectMsg(T_HB, 0, 0);
    pwrState = 2'b01;
    wait (doneCount == 1);
    gapArm = 1;
    wait (doneCount == 2);
    gapArm = 0;
    pwrState = 2'b00;

    // R3: lockup enables heartbeats in working
    expectMsg(T_HB, 0, 0);
    lockedUp = 1'b1;
    wait (doneCount == 3);
    lockedUp = 1'b0;

    // R4: edges in sleep, both polarities, two lines at once
    base = doneCount;
    expectMsg(T_EVT, 3'b010, 0);
    pwrState = 2'b01;
    evtIn[1] = 1'b1;
    wait (doneCount == base + 1);
    expectMsg(T_EVT, 3'b010, 0);
    evtIn[1] = 1'b0;
    wait (doneCount == base + 2);
    expectMsg(T_EVT, 3'b101, 0);
    evtIn[0] = 1'b1; evtIn[2] = 1'b1;
    wait (doneCount == base + 3);
    pwrState = 2'b00;

    // R6: collision retries the same message
    base = doneCount; mc = msgCount;
    expectMsg(T_HB, 0, 1);
    collNext = 1;
    pwrState = 2'b01;
    wait (doneCount == base + 1);
    pwrState = 2'b00;
    check(msgCount - mc == 2, "R6 retry after collision", msgCount - mc, 2);

    // R6 busy bus holds the message; R7 it still goes after entering working
    mc = msgCount; base = doneCount;
    busIdle = 1'b0;
    pwrState = 2'b01;
    repeat (50) @(negedge clk);
    check(msgCount == mc, "R6 no request while bus busy", msgCount - mc, 0);
    pwrState = 2'b00;
    expectMsg(T_HB, 0, 0);
    busIdle = 1'b1;
    wait (doneCount == base + 1);
    check(doneCount == base + 1, "R7 chosen message completed", doneCount - base, 1);

    // R8: edge in working outside send-now is dropped
    mc = msgCount;
    evtIn[1] = 1'b1;
    repeat (10) @(negedge clk);
    pwrState = 2'b01;
    repeat (20) @(negedge clk);
    check(msgCount == mc, "R8 working edge dropped", msgCount - mc, 0);
    pwrState = 2'b00;
    repeat (4) @(negedge clk);

    // R8: edge during send-now yields one event after sleeping
    base = doneCount; mc = msgCount;
    respDelay = 12;
    expectMsg(T_NOW, 0, 0);
    pulse(sendNowReq);
    wait (msgCount == mc + 1);
    evtIn[2] = 1'b0;
    wait (doneCount == base + 1);
    respDelay = 2;
    repeat (10) @(negedge clk);
    check(msgCount == mc + 1, "R8 held while working", msgCount - mc, 1);
    expectMsg(T_EVT, 3'b100, 0);
    pwrState = 2'b01;
    wait (doneCount == base + 2);
    pwrState = 2'b00;
    repeat (15) @(negedge clk);
    check(msgCount == mc + 2, "R8 single extra alert", msgCount - mc, 2);

    // R5: wrap of the sequence number
    for (int k = 0; k < 18; k++) begin
      base = doneCount;
      expectMsg(T_NOW, 0, 0);
      pulse(sendNowReq);
      wait (doneCount == base + 1);
    end

    // R9: status set, heartbeats in working
    pulse(wdTimeout);
    check(secondToSts == 1'b1, "R9 status set", int'(secondToSts), 1);
    base = doneCount;
    expectMsg(T_HB, 0, 0);
    wait (doneCount == base + 1);

    // R10: one reset attempt, held until done; R4 event before heartbeat
    mc = msgCount;
    pulse(rstReq);
    repeat (3) @(negedge clk);
    check(sysRst == 1'b1, "R10 reset asserted", int'(sysRst), 1);
    pwrState = 2'b01;
    evtIn[0] = 1'b0;
    repeat (45) @(negedge clk);
    check(sysRst == 1'b1, "R10 reset held", int'(sysRst), 1);
    check(msgCount == mc, "R10 no message during reset", msgCount - mc, 0);
    base = doneCount;
    expectMsg(T_EVT, 3'b001, 0);
    expectMsg(T_HB, 0, 0);
    pulse(rstDone);
    wait (doneCount == base + 2);
    pwrState = 2'b00;
    check(sysRst == 1'b0, "R10 reset released", int'(sysRst), 0);
    pulse(rstReq);
    repeat (6) @(negedge clk);
    check(sysRst == 1'b0, "R10 second request ignored", int'(sysRst), 0);

    // R9: clear stops working-state heartbeats
    pulse(stsClr);
    check(secondToSts == 1'b0, "R9 status cleared", int'(secondToSts), 0);
    mc = msgCount;
    repeat (80) @(negedge clk);
    check(msgCount == mc, "R9 quiet after clear", msgCount - mc, 0);

    check(expQ.size() == 0, "R5 all expected messages seen", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule